// File: doc/BRIEF.md
# Circular Delay Buffer RAM Controller

This block shares one single-port RAM between two users. For most of the time the RAM is read continuously for display, with its address taken from an external video address source. A delay slot is requested by pulling an active-low request input low. During that slot the RAM address moves to an internal circular pointer. The controller then runs a fixed sequence on that one location: it reads the sample stored there and presents it as the delay output, turns the RAM output drivers off, drives the new converter sample onto the bus, and writes it back to the same location.

When the request returns high, the pointer advances by one. Over successive slots the RAM therefore acts as a fixed-length delay line. Each sample written comes back out exactly DEPTH slots later. The pointer runs from 0 to DEPTH-1 (1800 entries by default) and then wraps. A slot runs to completion once it has started, even if the request is released early. A new slot can only begin from the video state.

Top module: `dly_ram_ctrl`

## Requirements
- R1: After reset the controller is in video mode: ram_oe_o=1, ram_we_o=0, ram_wdata_en_o=0, dly_valid_o=0, and the first slot uses pointer address 0.
- R2: While idle with slot_req_ni high, ram_addr_o equals video_addr_i, ram_oe_o=1, ram_we_o=0 and video_valid_o=1.
- R3: From the cycle in which slot_req_ni is sampled low in video mode, and until the controller returns to video mode, ram_addr_o equals the delay pointer and video_valid_o=0.
- R4: In the first slot cycle (read state) ram_oe_o=1. The RAM data at the pointer address is captured at the end of that cycle. It appears on dly_data_o with dly_valid_o high for exactly one cycle, which is the cycle after the read.
- R5: After the read there is exactly one turnaround cycle with ram_oe_o=0, ram_wdata_en_o=0 and ram_we_o=0. ram_oe_o and ram_wdata_en_o are never high together.
- R6: adc_data_i is sampled at the end of the turnaround cycle. It is driven on ram_wdata_o with ram_wdata_en_o=1 for one cycle with ram_we_o=0. ram_we_o then rises while the data stays stable, so the sample is written at the address just read.
- R7: ram_we_o stays high and the pointer holds while slot_req_ni stays low after the write. At the first clock edge with slot_req_ni high in that state, the controller returns to video mode and the pointer increments by one.
- R8: The pointer goes from DEPTH-1 back to 0, so the sample written at an address is read back DEPTH slots later.
- R9: If slot_req_ni is released before the write completes, the full read, turnaround and write sequence still runs, and the controller returns to video mode one cycle after the write strobe rises.
- R10: After a slot, the RAM address returns to video_addr_i with ram_oe_o=1, and a new slot can start on the next edge at which slot_req_ni is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_req_ni | input | 1 | Delay slot request, active low |
| video_addr_i | input | AW | Video refresh address |
| adc_data_i | input | DW | Converter sample to store |
| ram_rdata_i | input | DW | RAM read data |
| ram_addr_o | output | AW | RAM address |
| ram_oe_o | output | 1 | RAM output enable, active high |
| ram_we_o | output | 1 | RAM write strobe, write on rising edge |
| ram_wdata_o | output | DW | Data driven toward RAM |
| ram_wdata_en_o | output | 1 | Write data driver enable |
| dly_data_o | output | DW | Delayed sample read in the slot |
| dly_valid_o | output | 1 | One-cycle strobe for dly_data_o |
| video_valid_o | output | 1 | RAM is serving video reads |

## Verification
The hardest situation to reach is the pointer wrap together with the matching delay line behaviour: a sample only comes back after 1800 complete slots. The bench runs that many short back-to-back slots with a distinct sample in each one. It keeps a shadow of the RAM contents and checks the address and the delayed sample returned on every slot, including the slots after the pointer returns to 0. Early release and a held request are mixed in to cover the length of the write state.

// File: rtl/dly_ram_pkg.sv
package dly_ram_pkg;
  typedef enum logic [2:0] {
    S_VIDEO = 3'd0,
    S_RD    = 3'd1,
    S_TURN  = 3'd2,
    S_WR    = 3'd3,
    S_DONE  = 3'd4
  } slot_state_e;
endpackage

// File: rtl/dly_slot_fsm.sv
module dly_slot_fsm
  import dly_ram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slot_req_ni,
  output logic video_sel_o,
  output logic oe_o,
  output logic wdata_en_o,
  output logic we_o,
  output logic rd_cap_o,
  output logic wr_load_o,
  output logic ptr_inc_o
);
  slot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_VIDEO: if (!slot_req_ni) state_d = S_RD;
      S_RD:    state_d = S_TURN;
      S_TURN:  state_d = S_WR;
      S_WR:    state_d = S_DONE;
      S_DONE:  if (slot_req_ni) state_d = S_VIDEO;
      default: state_d = S_VIDEO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= S_VIDEO;
    else         state_q <= state_d;

  assign video_sel_o = (state_q == S_VIDEO) && slot_req_ni;
  assign oe_o        = (state_q == S_VIDEO) || (state_q == S_RD);
  assign wdata_en_o  = (state_q == S_WR) || (state_q == S_DONE);
  assign we_o        = (state_q == S_DONE);
  assign rd_cap_o    = (state_q == S_RD);
  assign wr_load_o   = (state_q == S_TURN);
  assign ptr_inc_o   = (state_q == S_DONE) && slot_req_ni;

  // R5
  oe_fall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> !wdata_en_o && !we_o);

  // R5
  drive_after_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdata_en_o) |-> !$past(oe_o) && !$past(wdata_en_o));

  // R9
  slot_runs_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cap_o |=> wr_load_o);
endmodule

// File: rtl/dly_ptr_ctr.sv
module dly_ptr_ctr #(
  parameter int unsigned DEPTH = 1800,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               ptr_q <= '0;
    else if (inc_i)
      if (ptr_q == LAST)       ptr_q <= '0;
      else                     ptr_q <= ptr_q + 1'b1;

  assign ptr_o = ptr_q;

  // R8
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ptr_q == LAST) |=> ptr_q == '0);

  // R7
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);

  // R7
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(ptr_q));

  // R8
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);
endmodule

// File: rtl/dly_data_path.sv
module dly_data_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_cap_i,
  input  logic          wr_load_i,
  input  logic          wdata_en_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [DW-1:0] adc_data_i,
  output logic [DW-1:0] dly_data_o,
  output logic          dly_valid_o,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0] dly_q, wdata_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dly_q   <= '0;
      valid_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      valid_q <= rd_cap_i;
      if (rd_cap_i)  dly_q   <= ram_rdata_i;
      if (wr_load_i) wdata_q <= adc_data_i;
    end

  assign dly_data_o  = dly_q;
  assign dly_valid_o = valid_q;
  assign wdata_o     = wdata_en_i ? wdata_q : '0;

  // R4
  dly_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);

  // R4
  dly_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cap_i |=> valid_q && dly_q == $past(ram_rdata_i));
endmodule

// File: rtl/dly_ram_ctrl.sv
module dly_ram_ctrl #(
  parameter int unsigned DEPTH = 1800,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          slot_req_ni,
  input  logic [AW-1:0] video_addr_i,
  input  logic [DW-1:0] adc_data_i,
  input  logic [DW-1:0] ram_rdata_i,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_oe_o,
  output logic          ram_we_o,
  output logic [DW-1:0] ram_wdata_o,
  output logic          ram_wdata_en_o,
  output logic [DW-1:0] dly_data_o,
  output logic          dly_valid_o,
  output logic          video_valid_o
);
  logic          video_sel, rd_cap, wr_load, ptr_inc;
  logic [AW-1:0] ptr;

  dly_slot_fsm i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .slot_req_ni (slot_req_ni),
    .video_sel_o (video_sel),
    .oe_o        (ram_oe_o),
    .wdata_en_o  (ram_wdata_en_o),
    .we_o        (ram_we_o),
    .rd_cap_o    (rd_cap),
    .wr_load_o   (wr_load),
    .ptr_inc_o   (ptr_inc)
  );

  dly_ptr_ctr #(.DEPTH(DEPTH)) i_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (ptr_inc),
    .ptr_o  (ptr)
  );

  dly_data_path #(.DW(DW)) i_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_cap_i    (rd_cap),
    .wr_load_i   (wr_load),
    .wdata_en_i  (ram_wdata_en_o),
    .ram_rdata_i (ram_rdata_i),
    .adc_data_i  (adc_data_i),
    .dly_data_o  (dly_data_o),
    .dly_valid_o (dly_valid_o),
    .wdata_o     (ram_wdata_o)
  );

  assign ram_addr_o    = video_sel ? video_addr_i : ptr;
  assign video_valid_o = video_sel;

  // R6
  we_data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_o) |-> $past(ram_wdata_en_o) && $stable(ram_wdata_o));

  // R3
  slot_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!video_valid_o && $past(!video_valid_o) && !$past(ptr_inc)) |-> $stable(ram_addr_o));

  // R6
  we_needs_driver_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> ram_wdata_en_o && !ram_oe_o);
endmodule

// File: tb/test_dly_ram_ctrl.sv
module test_dly_ram_ctrl;
  localparam int  DEPTH   = 1800;
  localparam int  DW      = 8;
  localparam int  AW      = $clog2(DEPTH);
  localparam time CLK_PER = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slot_req_n = 1'b1;
  logic [AW-1:0] video_addr = '0;
  logic [DW-1:0] adc_data = '0;
  logic [DW-1:0] ram_rdata;
  logic [AW-1:0] ram_addr;
  logic          ram_oe, ram_we, ram_wdata_en, dly_valid, video_valid;
  logic [DW-1:0] ram_wdata, dly_data;

  logic [DW-1:0] mem    [2**AW];
  logic [DW-1:0] shadow [2**AW];
  int            exp_ptr = 0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  assign ram_rdata = ram_oe ? mem[ram_addr] : '0;
  always @(posedge ram_we) mem[ram_addr] <= ram_wdata;

  dly_ram_ctrl #(.DEPTH(DEPTH), .DW(DW)) i_dly_ram_ctrl (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .slot_req_ni    (slot_req_n),
    .video_addr_i   (video_addr),
    .adc_data_i     (adc_data),
    .ram_rdata_i    (ram_rdata),
    .ram_addr_o     (ram_addr),
    .ram_oe_o       (ram_oe),
    .ram_we_o       (ram_we),
    .ram_wdata_o    (ram_wdata),
    .ram_wdata_en_o (ram_wdata_en),
    .dly_data_o     (dly_data),
    .dly_valid_o    (dly_valid),
    .video_valid_o  (video_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic video_check(input logic [AW-1:0] va);
    video_addr = va;
    #1;
    chk(ram_addr == va, "R2 addr", ram_addr, va);
    chk(ram_oe && !ram_we && video_valid, "R2 ctrl",
        {ram_oe, ram_we, video_valid}, 3'b101);
  endtask

  // One delay slot; early releases during read, hold adds cycles in write state
  task automatic do_slot(input logic [DW-1:0] smp, input bit early, input int hold, input bit full);
    logic [DW-1:0] exp_dly = shadow[exp_ptr];
    slot_req_n = 1'b0;
    #1;
    if (full) chk(ram_addr == AW'(exp_ptr), "R3 addr at request", ram_addr, exp_ptr);
    @(negedge clk);
    if (full) begin
      chk(ram_oe && !ram_wdata_en && !ram_we, "R4 read ctrl",
          {ram_oe, ram_wdata_en, ram_we}, 3'b100);
      chk(!video_valid, "R3 video off", video_valid, 0);
    end
    chk(ram_addr == AW'(exp_ptr), "R3 slot addr", ram_addr, exp_ptr);
    if (early) slot_req_n = 1'b1;
    @(negedge clk);
    chk(dly_valid && dly_data == exp_dly, "R4 delay data", dly_data, exp_dly);
    if (full)
      chk(!ram_oe && !ram_wdata_en && !ram_we, "R5 turnaround",
          {ram_oe, ram_wdata_en, ram_we}, 3'b000);
    adc_data = smp;
    @(negedge clk);
    adc_data = ~smp;
    chk(!dly_valid, "R4 pulse length", dly_valid, 0);
    chk(ram_wdata_en && !ram_we && !ram_oe && ram_wdata == smp, "R6 drive",
        ram_wdata, smp);
    @(negedge clk);
    chk(ram_we && ram_wdata == smp, "R6 strobe", {ram_we, ram_wdata}, {1'b1, smp});
    chk(mem[exp_ptr] == smp, "R6 written", mem[exp_ptr], smp);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(ram_we && !video_valid && ram_addr == AW'(exp_ptr), "R7 hold",
          ram_addr, exp_ptr);
    end
    slot_req_n = 1'b1;
    shadow[exp_ptr] = smp;
    exp_ptr = (exp_ptr == DEPTH - 1) ? 0 : exp_ptr + 1;
    @(negedge clk);
    if (full) begin
      chk(video_valid && ram_oe && !ram_we && !ram_wdata_en, "R10 resume",
          {video_valid, ram_oe, ram_we, ram_wdata_en}, 4'b1100);
      chk(ram_addr == video_addr, "R10 video addr", ram_addr, video_addr);
    end
  endtask

  task automatic test_reset();
    chk(ram_oe && !ram_we && !ram_wdata_en && !dly_valid, "R1 reset outputs",
        {ram_oe, ram_we, ram_wdata_en, dly_valid}, 4'b1000);
    video_check(AW'(17));
  endtask

  task automatic test_video();
    for (int i = 0; i < 6; i++) begin
      video_check(AW'(i * 313 + 5));
      @(negedge clk);
    end
  endtask

  task automatic test_slots();
    do_slot(8'hA5, 1'b0, 0, 1'b1);          // first slot at addr 0 (R1)
    do_slot(8'h3C, 1'b1, 0, 1'b1);          // R9 early release
    do_slot(8'h77, 1'b0, 3, 1'b1);          // R7 held request
    video_check(AW'(1000));
    chk(ram_addr == AW'(1000), "R10 back to video", ram_addr, 1000);
  endtask

  task automatic test_wrap();
    for (int k = 0; k < DEPTH + 6; k++)
      do_slot(DW'(k * 7 + 3), k[0], 0, (k % 300) == 0 || k >= DEPTH - 4);
    chk(exp_ptr == 9, "R8 pointer after wrap", exp_ptr, 9);
  endtask

  initial begin
    for (int a = 0; a < 2**AW; a++) begin
      mem[a]    = DW'(a) ^ 8'h5A;
      shadow[a] = DW'(a) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    #1;
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_video();
    test_slots();
    test_wrap();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule